// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Turnaround Idle Insertion

This block runs read and write cycles on an external memory bus for a CPU-side request port. Each accepted request becomes one bus cycle: a read holds its area's chip select and the read strobe low for `RD_STATES` states and captures the returned data in its last state. A write drives the data bus for two states and pulses the write strobe in the second state only. The area is taken from the top `AREA_W` address bits, and each area has its own active-low chip select.

Some devices are slow to release the data bus after a read. When two cycles follow each other with no free state between them, the sequencer can place one quiet state ahead of the new cycle, so that a device still driving the bus cannot collide with the next driver. Two enable bits control this, and both reset to 1. The turnaround enable covers a write that follows a read. The area-change enable covers a read that follows a read to another area. A two-bit configuration write port changes the enables.

Top module: `ext_bus_idle_seq`

## Requirements
- R1: After reset, every chip select, `rd_n_o` and `wr_n_o` are high, `data_oe_o` is low, `req_ready_o` is high, and both idle enables are 1.
- R2: A read to area A holds `cs_n_o[A]` low and `rd_n_o` low for exactly `RD_STATES` consecutive states. `rsp_valid_o` is high for one cycle after the last of these states, and `rsp_rdata_o` then carries the `rdata_i` value sampled in that last state.
- R3: A write holds `data_oe_o` high for two consecutive states. `bus_wdata_o` carries the request data in both states, and `wr_n_o` is low in the second state only.
- R4: When the turnaround enable is 1 and a write is accepted in the last state of a read, exactly one quiet state comes before the write's first state. In a quiet state all chip selects and both strobes are high and `data_oe_o` is low.
- R5: When the turnaround enable is 0, a write accepted in the last state of a read starts in the very next state.
- R6: When the area-change enable is 1, a read accepted in the last state of a read to a different area is preceded by exactly one quiet state. A read to the same area gets no quiet state.
- R7: When the area-change enable is 0, a read to a different area that directly follows a read gets no quiet state.
- R8: No quiet state is inserted after a write cycle, and none is inserted for a request accepted while the bus is idle.
- R9: `req_ready_o` is high only while the bus is idle or in the last state of a cycle. A request is taken when `req_valid_i` and `req_ready_o` are both high at a clock edge, and the bus address does not change while the current cycle waits for that edge.
- R10: A cycle with `cfg_we_i` high loads `cfg_wdata_i`. Bit 0 is the turnaround enable and bit 1 is the area-change enable.
- R11: At most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one bus state per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken at this edge |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address; top AREA_W bits select the area |
| req_wdata_i | input | DATA_W | Write data |
| cfg_we_i | input | 1 | Load idle enables |
| cfg_wdata_i | input | 2 | Bit 0 turnaround enable, bit 1 area-change enable |
| rdata_i | input | DATA_W | Data returned by the device |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DATA_W | Captured read data |
| bus_addr_o | output | ADDR_W | External address |
| cs_n_o | output | 2**AREA_W | Per-area chip selects, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| data_oe_o | output | 1 | Data bus output enable |
| bus_wdata_o | output | DATA_W | Data driven during writes |

## Verification
All bus outputs come straight from registers. An access accepted from idle therefore shows its first state in the cycle right after the accepting edge, and an inserted quiet state delays that by exactly one cycle. The read response appears one cycle after the last read state. The bench changes inputs and samples outputs on falling edges only, and it logs the bus phase once per cycle. Turnaround is measured as the number of quiet entries between the end of the first cycle, whose known length is 3 or 2 states, and the start of the second.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GAP  = 2'd1,
    PH_ACC  = 2'd2
  } ebi_phase_e;

  localparam int unsigned CFG_TURN_BIT = 0;
  localparam int unsigned CFG_AREA_BIT = 1;
endpackage

// File: rtl/ebi_cfg_reg.sv
module ebi_cfg_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  output logic       turn_en_o,
  output logic       area_en_o
);
  import ebi_pkg::*;

  logic [1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= 2'b11;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign turn_en_o = cfg_q[CFG_TURN_BIT];
  assign area_en_o = cfg_q[CFG_AREA_BIT];

  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (turn_en_o == $past(wdata_i[CFG_TURN_BIT])) && (area_en_o == $past(wdata_i[CFG_AREA_BIT])));
endmodule

// File: rtl/ebi_gap_decider.sv
module ebi_gap_decider #(
  parameter int unsigned AREA_W = 3
) (
  input  logic              back2back_i,
  input  logic              prev_write_i,
  input  logic [AREA_W-1:0] prev_area_i,
  input  logic              next_write_i,
  input  logic [AREA_W-1:0] next_area_i,
  input  logic              turn_en_i,
  input  logic              area_en_i,
  output logic              insert_o
);
  logic after_read;

  // only a read can leave a slow driver on the bus
  assign after_read = back2back_i && !prev_write_i;

  always_comb begin
    insert_o = 1'b0;
    if (after_read) begin
      if (next_write_i) insert_o = turn_en_i;
      else              insert_o = area_en_i && (next_area_i != prev_area_i);
    end
  end
endmodule

// File: rtl/ebi_cs_decode.sv
module ebi_cs_decode #(
  parameter int unsigned AREA_W = 3,
  localparam int unsigned AREAS = 1 << AREA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [AREA_W-1:0] area_i,
  output logic [AREAS-1:0]  cs_n_o
);
  for (genvar a = 0; a < AREAS; a++) begin : g_cs
    assign cs_n_o[a] = !(active_i && (area_i == AREA_W'(a)));
  end

  p_cs_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
endmodule

// File: rtl/ext_bus_idle_seq.sv
module ext_bus_idle_seq #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned AREA_W    = 3,
  parameter int unsigned RD_STATES = 3,
  localparam int unsigned AREAS    = 1 << AREA_W,
  localparam int unsigned CNT_W    = (RD_STATES > 2) ? $clog2(RD_STATES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [AREAS-1:0]  cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] bus_wdata_o
);
  import ebi_pkg::*;

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_STATES - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(1);

  ebi_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cur_write_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [DATA_W-1:0] cur_wdata_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic turn_en, area_en, insert, last_acc, accept, in_acc;
  logic [AREA_W-1:0] cur_area, req_area;

  assign cur_area = cur_addr_q[ADDR_W-1 -: AREA_W];
  assign req_area = req_addr_i[ADDR_W-1 -: AREA_W];
  assign in_acc   = (phase_q == PH_ACC);
  assign last_acc = in_acc && (cnt_q == (cur_write_q ? WR_LAST : RD_LAST));

  assign req_ready_o = (phase_q == PH_IDLE) || last_acc;
  assign accept      = req_valid_i && req_ready_o;

  ebi_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .turn_en_o (turn_en),
    .area_en_o (area_en)
  );

  ebi_gap_decider #(.AREA_W(AREA_W)) u_dec (
    .back2back_i  (last_acc),
    .prev_write_i (cur_write_q),
    .prev_area_i  (cur_area),
    .next_write_i (req_write_i),
    .next_area_i  (req_area),
    .turn_en_i    (turn_en),
    .area_en_i    (area_en),
    .insert_o     (insert)
  );

  ebi_cs_decode #(.AREA_W(AREA_W)) u_cs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (in_acc),
    .area_i   (cur_area),
    .cs_n_o   (cs_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      cur_write_q <= 1'b0;
      cur_addr_q  <= '0;
      cur_wdata_q <= '0;
    end else if (accept) begin
      phase_q     <= insert ? PH_GAP : PH_ACC;
      cnt_q       <= '0;
      cur_write_q <= req_write_i;
      cur_addr_q  <= req_addr_i;
      cur_wdata_q <= req_wdata_i;
    end else if (phase_q == PH_GAP) begin
      phase_q <= PH_ACC;
      cnt_q   <= '0;
    end else if (last_acc) begin
      phase_q <= PH_IDLE;
    end else if (in_acc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= last_acc && !cur_write_q;
      if (last_acc && !cur_write_q) rsp_rdata_q <= rdata_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign bus_addr_o  = cur_addr_q;
  assign bus_wdata_o = cur_wdata_q;
  assign rd_n_o      = !(in_acc && !cur_write_q);
  assign wr_n_o      = !(in_acc && cur_write_q && (cnt_q == WR_LAST));
  assign data_oe_o   = in_acc && cur_write_q;

  p_gap_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_GAP) |-> (&cs_n_o && rd_n_o && wr_n_o && !data_oe_o));

  p_gap_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_GAP) |=> (phase_q == PH_ACC));

  p_turn_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && last_acc && !cur_write_q && req_write_i && turn_en) |=> (phase_q == PH_GAP));

  p_after_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && last_acc && cur_write_q) |=> (phase_q == PH_ACC));

  p_from_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (phase_q == PH_IDLE)) |=> (phase_q == PH_ACC));

  p_hold_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_acc && !req_ready_o) |=> $stable(bus_addr_o));

  p_wr_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> data_oe_o);

  p_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!rd_n_o));
endmodule

// File: tb/ext_bus_idle_seq_tb.sv
`timescale 1ns/1ps
module ext_bus_idle_seq_tb;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned AREA_W = 3;
  localparam int unsigned AREAS  = 1 << AREA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, cfg_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, rdata = 16'hA5C3;
  logic [1:0] cfg_wdata = 2'b11;
  logic req_ready, rsp_valid, rd_n, wr_n, data_oe;
  logic [DATA_W-1:0] rsp_rdata, bus_wdata;
  logic [ADDR_W-1:0] bus_addr;
  logic [AREAS-1:0] cs_n;

  int n_chk = 0, n_fail = 0;
  int idx = 0;
  logic rec_en = 1'b0;
  logic quiet_log [0:63];
  int   cs_log    [0:63];

  always #2.5 clk = ~clk;

  ext_bus_idle_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .rdata_i(rdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bus_addr_o(bus_addr), .cs_n_o(cs_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .data_oe_o(data_oe), .bus_wdata_o(bus_wdata)
  );

  always @(negedge clk) begin
    if (rec_en && idx < 64) begin
      quiet_log[idx] = (&cs_n) && rd_n && wr_n && !data_oe;
      cs_log[idx]    = $countones(~cs_n);
      idx = idx + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] area_addr(input int a);
    return ADDR_W'(a) << (ADDR_W - AREA_W);
  endfunction

  // present a request at a falling edge; return at the falling edge after it is taken
  task automatic send(input logic w, input int area, input logic [DATA_W-1:0] d);
    logic r;
    req_valid = 1'b1; req_write = w; req_addr = area_addr(area) | 16'h0012; req_wdata = d;
    forever begin
      r = req_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    check(&cs_n && rd_n && wr_n && !data_oe, "R1 bus quiet after reset", {cs_n, rd_n, wr_n, data_oe}, {{AREAS{1'b1}}, 3'b110});
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
  endtask

  task automatic t_read;
    send(1'b0, 2, '0);
    req_valid = 1'b0;
    check(cs_n == ~(AREAS'(1) << 2) && !rd_n, "R2 read state 1 strobes", {cs_n, rd_n}, {~(AREAS'(1) << 2), 1'b0});
    check(!req_ready, "R9 not ready in first read state", req_ready, 0);
    @(negedge clk);
    check(!rd_n && !req_ready, "R9 read state 2 busy", {rd_n, req_ready}, 0);
    @(negedge clk);
    check(!rd_n && cs_n[2] == 1'b0 && req_ready, "R2 read state 3 strobe, R9 ready", {cs_n[2], rd_n, req_ready}, 1);
    rdata = 16'h3C5A;
    @(negedge clk);
    check(rd_n && &cs_n, "R2 read ends after three states", {cs_n, rd_n}, {{AREAS{1'b1}}, 1'b1});
    check(rsp_valid && rsp_rdata == 16'h3C5A, "R2 response data", {rsp_valid, rsp_rdata}, {1'b1, 16'h3C5A});
    @(negedge clk);
    check(!rsp_valid, "R2 response one cycle", rsp_valid, 0);
  endtask

  task automatic t_write;
    send(1'b1, 5, 16'hBEEF);
    req_valid = 1'b0;
    check(data_oe && wr_n && !cs_n[5] && bus_wdata == 16'hBEEF, "R3 write state 1 / R8 no gap from idle",
          {data_oe, wr_n, bus_wdata}, {2'b11, 16'hBEEF});
    @(negedge clk);
    check(data_oe && !wr_n && bus_wdata == 16'hBEEF, "R3 write state 2 strobe", {data_oe, wr_n, bus_wdata}, {2'b10, 16'hBEEF});
    @(negedge clk);
    check(!data_oe && wr_n && &cs_n, "R3 write ends after two states", {data_oe, wr_n}, 2'b01);
  endtask

  task automatic t_pair(input logic w0, input int a0, input logic w1, input int a1,
                        input int exp_gap, input string tag);
    int s, k, g, l0, multi;
    @(negedge clk);
    idx = 0; rec_en = 1'b1;
    send(w0, a0, 16'h1111);
    send(w1, a1, 16'h2222);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    rec_en = 1'b0;
    s = 0;
    while (s < idx && quiet_log[s]) s++;
    l0 = w0 ? 2 : 3;
    k = s + l0; g = 0;
    while (k < idx && quiet_log[k]) begin g++; k++; end
    check(g == exp_gap && k + 3 < idx, tag, g, exp_gap);
    multi = 0;
    for (int i = 0; i < idx; i++) if (cs_log[i] > 1) multi++;
    check(multi == 0, "R11 single chip select", multi, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_pair(1'b0, 1, 1'b1, 1, 1, "R4 write after read gets one idle (enable reset to 1, R1)");
    t_pair(1'b0, 1, 1'b0, 3, 1, "R6 read after read to other area gets one idle (R1 reset enable)");
    t_pair(1'b0, 3, 1'b0, 3, 0, "R6 read after read same area no idle");
    t_pair(1'b1, 2, 1'b0, 4, 0, "R8 read after write no idle");
    t_pair(1'b1, 2, 1'b1, 2, 0, "R8 write after write no idle");
    set_cfg(2'b10);
    t_pair(1'b0, 1, 1'b1, 1, 0, "R5 R10 write after read, turnaround disabled");
    t_pair(1'b0, 1, 1'b0, 6, 1, "R10 area enable kept at 1");
    set_cfg(2'b01);
    t_pair(1'b0, 1, 1'b0, 6, 0, "R7 R10 other-area read, area enable 0");
    t_pair(1'b0, 1, 1'b1, 2, 1, "R10 turnaround enable back to 1");
    set_cfg(2'b11);
    t_write();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule